// File: doc/BRIEF.md
# Tick-Driven 64-bit Compare Timer

This block keeps a 64-bit timestamp that counts microsecond ticks from the moment reset is released, with no set-up by software. A divider turns the system clock into the tick. A single compare channel raises a sticky match flag once the timestamp has reached a programmed 64-bit value. The interrupt pin shows that flag only while the compare is enabled. Software reaches the block through a 32-bit register port. Because every value is wider than one word, the port takes two steps to read or write it safely. Reading the low counter word freezes a copy of the high word for the read that follows. Writing the high compare word only stages it. The staged value joins the compare at the moment the low word is written.

The register port carries no handshake and never stalls. A request is taken on any clock where `req_valid` is high. A read returns its data one clock later with `rsp_valid` high. Writes to the counter words or to unmapped offsets are ignored. The usual sequence for software is to disable the compare, read the counter, write the high and then the low compare word for the wanted delay (at least 100 ticks ahead), and enable the compare again. In the interrupt routine, software disables the compare and clears the flag. A test input lets the counter tick on every clock so that simulations run faster.

Top module: `tcmp_timer`

## Requirements
- R1: When `tick_bypass` is 0, the counter advances by exactly one every CLK_HZ/TICK_HZ clocks. When `tick_bypass` is 1, it advances by one every clock. It advances in both cases whatever the compare state.
- R2: After reset the counter starts at CNT_INIT and runs with no register writes.
- R3: A read of offset 0x00 returns counter bits 31:0 and copies bits 63:32 into a shadow. A read of offset 0x04 returns the shadow, not the live high word.
- R4: A write to offset 0x0C stages the high compare word only. A write to offset 0x08 loads the active 64-bit compare as {staged high, written low}.
- R5: Offsets 0x08 and 0x0C read back the low and high halves of the active compare value.
- R6: At offset 0x10, bit 0 is the compare enable and bit 1 is its write-enable. A write changes the enable only when bit 1 of the data is 1. A read returns the enable in bit 0 and zeros elsewhere.
- R7: While the compare is enabled, the match flag sets on the tick that brings the counter to a value greater than or equal to the compare. It never sets while the counter is below the compare.
- R8: The match flag reads at bit 0 of offset 0x14. It stays set until a write to 0x14 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it unchanged.
- R9: `irq` equals the match flag ANDed with the enable. Disabling the compare drops `irq` on the next clock without clearing the flag.
- R10: Enabling the compare when its value is already at or below the counter sets the flag on the next tick.
- R11: Reads of unmapped offsets return 0. Writes to 0x00, 0x04 or unmapped offsets change nothing.
- R12: Every read request gives `rsp_valid` high on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_bypass | input | 1 | 1: one tick per clock (test speed-up) |
| req_valid | input | 1 | Register request present this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one clock after a read) |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Compare-match interrupt, level |

## Verification
The hardest case to reach from the ports is a carry from the low counter word into the high word between the two halves of a read. At a microsecond rate that carry would take over an hour to arrive. The bench therefore builds the block with CNT_INIT a little below 2^32 and runs with one tick per clock. It polls the low word until the carry is close, reads the low word just before the carry, and reads the high word after the carry. The high word must still read as 0. A fresh pair of reads then returns 1. Staging of the compare is shown by loading a high word far ahead, checking that no interrupt comes, and then checking that a lone high write has no effect until the low write commits it.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned HI_W   = CNT_W - WORD_W;

  localparam logic [7:0] OFS_CNT_LO = 8'h00;
  localparam logic [7:0] OFS_CNT_HI = 8'h04;
  localparam logic [7:0] OFS_CMP_LO = 8'h08;
  localparam logic [7:0] OFS_CMP_HI = 8'h0C;
  localparam logic [7:0] OFS_CTRL   = 8'h10;
  localparam logic [7:0] OFS_STAT   = 8'h14;

  typedef enum logic [2:0] {
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_CTRL,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_CNT_LO: decode_ofs = SEL_CNT_LO;
      OFS_CNT_HI: decode_ofs = SEL_CNT_HI;
      OFS_CMP_LO: decode_ofs = SEL_CMP_LO;
      OFS_CMP_HI: decode_ofs = SEL_CMP_HI;
      OFS_CTRL:   decode_ofs = SEL_CTRL;
      OFS_STAT:   decode_ofs = SEL_STAT;
      default:    decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tcmp_prescaler.sv
module tcmp_prescaler #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  output logic tick
);
  localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  generate
    if (DIV <= 1) begin : g_nodiv
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ bypass;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] div_q;
      logic          wrap;

      assign wrap = (div_q == CW'(DIV - 1));

      always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (wrap) div_q <= '0;
        else           div_q <= div_q + CW'(1);
      end

      assign tick = bypass | wrap;
    end
  endgenerate
endmodule

// File: rtl/tcmp_counter.sv
module tcmp_counter
  import tcmp_pkg::*;
#(
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             snap,
  output logic [CNT_W-1:0] cnt,
  output logic [HI_W-1:0]  shadow
);
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  shadow_q;

  // Free-running: no enable other than the tick
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= CNT_INIT;
    else if (tick) cnt_q <= cnt_q + CNT_W'(1);
  end

  // Capture the upper half at the same edge the lower half is returned
  always_ff @(posedge clk) begin
    if (!rst_n)    shadow_q <= '0;
    else if (snap) shadow_q <= cnt_q[CNT_W-1:WORD_W];
  end

  assign cnt    = cnt_q;
  assign shadow = shadow_q;
endmodule

// File: rtl/tcmp_compare.sv
module tcmp_compare
  import tcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctrl,
  input  logic              clr,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              en,
  output logic              flag,
  output logic              irq
);
  logic [HI_W-1:0]  hi_stage_q;
  logic [CNT_W-1:0] cmp_q;
  logic             en_q;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;

  assign cnt_nxt = cnt + CNT_W'(1);
  // Judge the value the counter takes at this tick edge
  assign hit = tick & en_q & (cnt_nxt >= cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage_q <= '0;
      cmp_q      <= '0;
    end else begin
      if (wr_hi) hi_stage_q <= wdata[HI_W-1:0];
      if (wr_lo) cmp_q      <= {hi_stage_q, wdata};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 en_q <= 1'b0;
    else if (wr_ctrl & wdata[1]) en_q <= wdata[0];
  end

  // A new match wins over a same-cycle clear so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit | (flag_q & ~clr);
  end

  assign cmp_val = cmp_q;
  assign en      = en_q;
  assign flag    = flag_q;
  assign irq     = flag_q & en_q;
endmodule

// File: rtl/tcmp_timer.sv
module tcmp_timer
  import tcmp_pkg::*;
#(
  parameter int unsigned       CLK_HZ   = 100_000_000,
  parameter int unsigned       TICK_HZ  = 1_000_000,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [63:0]       CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_bypass,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  shadow_q;
  logic [CNT_W-1:0] cmp_val;
  logic             cmp_en;
  logic             match_flag;
  reg_sel_e         sel;
  logic             rd_req, wr_req;
  logic             snap;
  logic             stat_clear;
  logic [WORD_W-1:0] rd_mux;

  generate
    if (ADDR_W > 8) begin : g_wide
      assign sel = (req_addr[ADDR_W-1:8] == '0) ? decode_ofs(req_addr[7:0]) : SEL_NONE;
    end else begin : g_narrow
      assign sel = decode_ofs(8'(req_addr));
    end
  endgenerate

  assign rd_req     = req_valid & ~req_write;
  assign wr_req     = req_valid & req_write;
  assign snap       = rd_req & (sel == SEL_CNT_LO);
  assign stat_clear = wr_req & (sel == SEL_STAT) & req_wdata[0];

  tcmp_prescaler #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_presc (
    .clk(clk), .rst_n(rst_n), .bypass(tick_bypass), .tick(tick)
  );

  tcmp_counter #(.CNT_INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .snap(snap),
    .cnt(cnt_q), .shadow(shadow_q)
  );

  tcmp_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q),
    .wr_lo(wr_req & (sel == SEL_CMP_LO)),
    .wr_hi(wr_req & (sel == SEL_CMP_HI)),
    .wr_ctrl(wr_req & (sel == SEL_CTRL)),
    .clr(stat_clear), .wdata(req_wdata),
    .cmp_val(cmp_val), .en(cmp_en), .flag(match_flag), .irq(irq)
  );

  always_comb begin
    case (sel)
      SEL_CNT_LO: rd_mux = cnt_q[WORD_W-1:0];
      SEL_CNT_HI: rd_mux = shadow_q;
      SEL_CMP_LO: rd_mux = cmp_val[WORD_W-1:0];
      SEL_CMP_HI: rd_mux = cmp_val[CNT_W-1:WORD_W];
      SEL_CTRL:   rd_mux = {{(WORD_W-1){1'b0}}, cmp_en};
      SEL_STAT:   rd_mux = {{(WORD_W-1){1'b0}}, match_flag};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/tcmp_checker.sv
module tcmp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [63:0] cnt_q,
  input logic [31:0] shadow_q,
  input logic        snap,
  input logic [63:0] cmp_val,
  input logic        cmp_en,
  input logic        match_flag,
  input logic        stat_clear,
  input logic        irq,
  input logic        req_valid,
  input logic        req_write,
  input logic        rsp_valid
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_q == $past(cnt_q) + 64'($past(tick)));

  // R3
  shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snap) |-> shadow_q == $past(cnt_q[63:32]));

  // R7
  match_when_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(cmp_en) && $past(tick) && cnt_q >= $past(cmp_val));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(match_flag) && !$past(stat_clear)) |-> match_flag);

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |-> !irq);

  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

bind tcmp_timer tcmp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .shadow_q(shadow_q),
  .snap(snap), .cmp_val(cmp_val), .cmp_en(cmp_en), .match_flag(match_flag),
  .stat_clear(stat_clear), .irq(irq), .req_valid(req_valid),
  .req_write(req_write), .rsp_valid(rsp_valid)
);

// File: tb/tcmp_timer_tb.sv
module tcmp_timer_tb;
  localparam logic [63:0] INIT = 64'h0000_0000_FFFF_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_bypass = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tcmp_timer #(.CLK_HZ(100_000_000), .TICK_HZ(1_000_000), .ADDR_W(8), .CNT_INIT(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_bypass(tick_bypass),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R12 rsp_valid", longint'(rsp_valid), 1);
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    check(irq == 1'b0, "R9 irq at reset", longint'(irq), 0);
    bus_read(8'h10, a); check(a == 0, "R6 ctrl reset", longint'(a), 0);
    bus_read(8'h14, a); check(a == 0, "R8 status reset", longint'(a), 0);
    bus_read(8'h08, a); check(a == 0, "R5 cmp lo reset", longint'(a), 0);
    bus_read(8'h0C, a); check(a == 0, "R5 cmp hi reset", longint'(a), 0);
    bus_read(8'h00, a);
    check(a >= 32'hFFFF_F000 && a <= 32'hFFFF_F001, "R2 start value", longint'(a), 64'hFFFF_F000);
    bus_read(8'h04, b); check(b == 0, "R2 high word", longint'(b), 0);
    bus_read(8'h00, a);
    repeat (299) @(negedge clk);
    bus_read(8'h00, b);
    check(b - a == 3, "R2 runs without setup", longint'(b - a), 3);
  endtask

  task automatic t_rate();
    logic [31:0] a, b;
    bus_read(8'h00, a);
    repeat (999) @(negedge clk);
    bus_read(8'h00, b);
    check(b - a == 10, "R1 divided rate", longint'(b - a), 10);
    tick_bypass = 1'b1;
    @(negedge clk);
    bus_read(8'h00, a);
    repeat (99) @(negedge clk);
    bus_read(8'h00, b);
    check(b - a == 100, "R1 bypass rate", longint'(b - a), 100);
    tick_bypass = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ignore();
    logic [31:0] a;
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_read(8'h00, a);
    check(a >= 32'hFFFF_F000, "R11 counter write ignored", longint'(a), 64'hFFFF_F000);
    bus_read(8'h04, a); check(a == 0, "R11 high write ignored", longint'(a), 0);
    bus_read(8'h18, a); check(a == 0, "R11 unmapped read", longint'(a), 0);
    bus_read(8'h7C, a); check(a == 0, "R11 unmapped read far", longint'(a), 0);
    bus_read(8'h10, a); check(a == 0, "R11 ctrl untouched", longint'(a), 0);
  endtask

  task automatic t_ctrl_gate();
    logic [31:0] a;
    bus_write(8'h10, 32'h1);
    bus_read(8'h10, a); check(a == 0, "R6 no write-enable", longint'(a), 0);
    bus_write(8'h10, 32'h3);
    bus_read(8'h10, a); check(a == 1, "R6 enable set", longint'(a), 1);
    bus_write(8'h10, 32'h0);
    bus_read(8'h10, a); check(a == 1, "R6 clear gated", longint'(a), 1);
    bus_write(8'h10, 32'h2);
    bus_read(8'h10, a); check(a == 0, "R6 enable cleared", longint'(a), 0);
  endtask

  task automatic t_match();
    logic [31:0] v, a;
    tick_bypass = 1'b1;
    bus_write(8'h10, 32'h2);
    bus_write(8'h0C, 32'h0);
    bus_read(8'h00, v);
    bus_write(8'h08, v + 32'd150);
    bus_write(8'h10, 32'h3);
    repeat (40) @(negedge clk);
    check(irq == 1'b0, "R7 no early match", longint'(irq), 0);
    bus_read(8'h14, a); check(a == 0, "R7 flag low before", longint'(a), 0);
    repeat (200) @(negedge clk);
    check(irq == 1'b1, "R7 match irq", longint'(irq), 1);
    bus_read(8'h14, a); check(a == 1, "R7 flag set", longint'(a), 1);
    bus_write(8'h10, 32'h2);
    check(irq == 1'b0, "R9 irq drops on disable", longint'(irq), 0);
    bus_read(8'h14, a); check(a == 1, "R9 flag kept", longint'(a), 1);
    bus_write(8'h14, 32'h0);
    bus_read(8'h14, a); check(a == 1, "R8 write 0 no effect", longint'(a), 1);
    bus_write(8'h14, 32'h1);
    bus_read(8'h14, a); check(a == 0, "R8 write 1 clears", longint'(a), 0);
    repeat (5) @(negedge clk);
    bus_read(8'h14, a); check(a == 0, "R8 stays clear", longint'(a), 0);
    bus_write(8'h10, 32'h3);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R10 past compare", longint'(irq), 1);
    bus_write(8'h10, 32'h2);
    bus_write(8'h14, 32'h1);
  endtask

  task automatic t_stage();
    logic [31:0] a, old_lo;
    bus_read(8'h08, old_lo);
    bus_write(8'h0C, 32'h5);
    bus_read(8'h0C, a); check(a == 0, "R4 high staged only", longint'(a), 0);
    bus_read(8'h08, a); check(a == old_lo, "R5 low unchanged", longint'(a), longint'(old_lo));
    bus_write(8'h08, 32'h1234);
    bus_read(8'h0C, a); check(a == 5, "R5 high committed", longint'(a), 5);
    bus_read(8'h08, a); check(a == 32'h1234, "R5 low committed", longint'(a), 64'h1234);
    bus_write(8'h10, 32'h3);
    repeat (100) @(negedge clk);
    check(irq == 1'b0, "R7 far compare quiet", longint'(irq), 0);
    bus_write(8'h0C, 32'h0);
    repeat (20) @(negedge clk);
    check(irq == 1'b0, "R4 lone high write inert", longint'(irq), 0);
    bus_write(8'h08, 32'h10);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R4 low write commits", longint'(irq), 1);
    bus_write(8'h10, 32'h2);
    bus_write(8'h14, 32'h1);
  endtask

  task automatic t_wrap();
    logic [31:0] lo, hi;
    int guard = 0;
    tick_bypass = 1'b1;
    lo = '0;
    while (lo < 32'hFFFF_FF80 && guard < 20000) begin
      bus_read(8'h00, lo);
      guard++;
    end
    bus_read(8'h00, lo);
    check(lo > 32'hFFFF_FF00, "R3 near carry", longint'(lo), 64'hFFFF_FF80);
    repeat (200) @(negedge clk);
    bus_read(8'h04, hi);
    check(hi == 0, "R3 shadow holds pre-carry", longint'(hi), 0);
    bus_read(8'h00, lo);
    bus_read(8'h04, hi);
    check(hi == 1, "R3 fresh high after carry", longint'(hi), 1);
    check(lo < 32'h400, "R3 low after carry", longint'(lo), 64'h100);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_ignore();
    t_ctrl_gate();
    t_match();
    t_stage();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule